// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block holds a set of protection entries and decides, one access at a time, whether a memory access may proceed. Each entry pairs an 8-bit configuration byte with an address word. The configuration byte holds read, write and execute permission bits, an address-matching mode and a lock bit. Software loads the entries through a single write port. That port either writes a packed configuration word, which carries one byte for each of several entries, or writes the address word of a single entry.

On the check side the caller presents four things: a physical address, a size code, an access type, and the hart privilege with the status bits that redirect load/store privilege. One clock later the block returns a registered allow/deny verdict. The access counts as inside an entry only when both its first byte and its last byte lie within that entry's inclusive range. When just one of the two lies inside, the result is a denial and the search does not continue to later entries.

Entries are searched from the lowest index upward. The first entry that the access touches decides the result.

Top module: `pmp_checker`

## Requirements
- R1: Writing a configuration word (`csr_is_cfg`=1) with index k loads byte i (bits 8i+7..8i) into entry (k/S)*B + i, where B = XLEN/8 bytes per word and S = XLEN/32. Only indices that are multiples of S are legal. With XLEN=64 this means indices 0 and 2 reach entries 0–7 and 8–15, and an odd index changes no entry. Byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock.
- R2: Writing with `csr_is_cfg`=0 and index n loads the low PADDR_W-2 data bits into entry n's address word, which holds byte address bits PADDR_W-1..2.
- R3: While an entry's lock bit is set, writes to its configuration byte and its address word are ignored. A locked entry that matches applies its permissions to machine-mode accesses as well.
- R4: An entry in mode off never matches, whatever its address word and permission bits hold.
- R5: When no entry matches, a supervisor or user access is denied and a machine access is allowed. This covers the reset state, in which every entry is off.
- R6: The effective privilege is the MPP value when the hart is in machine mode (3) with MPRV set and the access is a load or store. Otherwise it is the hart privilege. Fetches never take the substitution. Privilege codes: 0 user, 1 supervisor, 3 machine.
- R7: Region upper bounds are inclusive. A 1-byte read of 0x87654FFF inside a 4 KB region at 0x87654000 is fully contained.
- R8: An access whose first byte (address) and last byte (address + size - 1) disagree on containment in the first entry touched is denied, at every privilege.
- R9: The four-byte mode covers exactly byte addresses {a,00} through {a,11}, where a is the stored address word.
- R10: Top-of-range mode covers {prev,00} through {a,00} - 1, where prev is the previous entry's address word (0 for entry 0). The region is empty when a <= prev.
- R11: In power-of-two mode, t trailing ones in the address word select a region of 2^(t+3) bytes, aligned to that size.
- R12: The lowest-numbered entry the access touches decides the result. Permission bit by access type: type 0 load uses read, 1 store uses write, 2 fetch uses execute.
- R13: `rsp_valid` is `chk_valid` delayed one cycle. `rsp_allow` is the registered verdict and is 0 whenever `rsp_valid` is 0. Both outputs are 0 during and after reset until a check is made.
- R14: A machine-mode access that fully matches an unlocked entry is allowed, whatever that entry's permission bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the entry registers |
| csr_is_cfg | input | 1 | 1: configuration word write, 0: address word write |
| csr_idx | input | $clog2(NUM_ENTRIES) | Configuration word index or entry number |
| csr_wdata | input | XLEN | Write data |
| chk_valid | input | 1 | Check request |
| chk_addr | input | PADDR_W | Byte address of the access |
| chk_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| chk_type | input | 2 | 0 load, 1 store, 2 fetch |
| chk_priv | input | 2 | Hart privilege: 0 user, 1 supervisor, 3 machine |
| chk_mprv | input | 1 | Load/store privilege redirect enable |
| chk_mpp | input | 2 | Privilege used when the redirect applies |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | 1 when the access is permitted |

## Verification
The assertions assume several things about the inputs. `chk_priv` and `chk_mpp` never carry the unused code 2, and `chk_type` never carries code 3. An access never wraps past the top of the physical address space. Configuration writes use an index below NUM_ENTRIES. The stimulus keeps within these limits: it uses only the three defined privilege codes and the three defined access types, it places every address far below 2^PADDR_W minus 8, and it writes only to configuration indices 0, 1 and 2. Index 1 is written on purpose, to show that an illegal index leaves every entry unchanged.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } ecfg_t;

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 64,
  parameter int AREG_W      = 32,
  parameter int IDX_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_is_cfg,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [XLEN-1:0]   csr_wdata,
  output ecfg_t             cfg_q  [NUM_ENTRIES],
  output logic [AREG_W-1:0] addr_q [NUM_ENTRIES]
);

  localparam int BPR    = XLEN / 8;
  localparam int STRIDE = XLEN / 32;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    localparam int KREG = (e / BPR) * STRIDE;
    localparam int BYTE = e % BPR;

    ecfg_t             c_r;
    logic [AREG_W-1:0] a_r;
    logic              cfg_hit;
    logic              addr_hit;

    assign cfg_hit  = csr_we &&  csr_is_cfg && (csr_idx == IDX_W'(KREG));
    assign addr_hit = csr_we && !csr_is_cfg && (csr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        c_r <= '0;
        a_r <= '0;
      end else if (!c_r.lock) begin
        if (cfg_hit)  c_r <= ecfg_t'(csr_wdata[BYTE*8 +: 8]);
        if (addr_hit) a_r <= csr_wdata[AREG_W-1:0];
      end
    end

    assign cfg_q[e]  = c_r;
    assign addr_q[e] = a_r;
  end

endmodule

// File: rtl/pmp_region.sv
module pmp_region
  import pmp_pkg::*;
#(
  parameter int PADDR_W = 34,
  parameter int AREG_W  = 32
) (
  input  amode_e             mode,
  input  logic [AREG_W-1:0]  addr_this,
  input  logic [AREG_W-1:0]  addr_prev,
  input  logic [PADDR_W-1:0] first_b,
  input  logic [PADDR_W-1:0] last_b,
  output logic               hit_full,
  output logic               hit_part
);

  logic [AREG_W-1:0]  ones_mask;
  logic [PADDR_W-1:0] byte_mask;
  logic [PADDR_W-1:0] lo;
  logic [PADDR_W-1:0] hi;
  logic               empty;
  logic               in_first;
  logic               in_last;

  always_comb begin
    // trailing ones plus the first zero above them
    ones_mask = addr_this ^ (addr_this + AREG_W'(1));
    byte_mask = {ones_mask, 2'b11};
    lo        = '0;
    hi        = '0;
    empty     = 1'b1;
    case (mode)
      AM_TOR: begin
        lo    = {addr_prev, 2'b00};
        hi    = {addr_this, 2'b00} - PADDR_W'(1);
        empty = (addr_this <= addr_prev);
      end
      AM_NA4: begin
        lo    = {addr_this, 2'b00};
        hi    = {addr_this, 2'b11};
        empty = 1'b0;
      end
      AM_NAPOT: begin
        lo    = {addr_this, 2'b00} & ~byte_mask;
        hi    = {addr_this, 2'b11} |  byte_mask;
        empty = 1'b0;
      end
      default: ;
    endcase
  end

  assign in_first = !empty && (first_b >= lo) && (first_b <= hi);
  assign in_last  = !empty && (last_b  >= lo) && (last_b  <= hi);
  assign hit_full = in_first && in_last;
  assign hit_part = in_first ^ in_last;

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] hit_full,
  input  logic [NUM_ENTRIES-1:0] hit_part,
  input  logic [NUM_ENTRIES-1:0] perm_r,
  input  logic [NUM_ENTRIES-1:0] perm_w,
  input  logic [NUM_ENTRIES-1:0] perm_x,
  input  logic [NUM_ENTRIES-1:0] locked,
  input  logic [1:0]             acc,
  input  logic [1:0]             priv,
  output logic                   allow
);

  logic [NUM_ENTRIES-1:0] perm_sel;
  logic                   found;

  always_comb begin
    case (acc)
      ACC_LOAD:  perm_sel = perm_r;
      ACC_STORE: perm_sel = perm_w;
      ACC_FETCH: perm_sel = perm_x;
      default:   perm_sel = '0;
    endcase
  end

  always_comb begin
    found = 1'b0;
    allow = (priv == PRIV_M);
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && (hit_full[i] || hit_part[i])) begin
        found = 1'b1;
        if (hit_part[i])                       allow = 1'b0;
        else if (priv != PRIV_M || locked[i])  allow = perm_sel[i];
        else                                   allow = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 64,
  parameter int PADDR_W     = 34,
  localparam int AREG_W     = PADDR_W - 2,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_we,
  input  logic               csr_is_cfg,
  input  logic [IDX_W-1:0]   csr_idx,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic               chk_valid,
  input  logic [PADDR_W-1:0] chk_addr,
  input  logic [1:0]         chk_size,
  input  logic [1:0]         chk_type,
  input  logic [1:0]         chk_priv,
  input  logic               chk_mprv,
  input  logic [1:0]         chk_mpp,
  output logic               rsp_valid,
  output logic               rsp_allow
);

  ecfg_t             cfg_q  [NUM_ENTRIES];
  logic [AREG_W-1:0] addr_q [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] hit_full;
  logic [NUM_ENTRIES-1:0] hit_part;
  logic [NUM_ENTRIES-1:0] perm_r;
  logic [NUM_ENTRIES-1:0] perm_w;
  logic [NUM_ENTRIES-1:0] perm_x;
  logic [NUM_ENTRIES-1:0] locked;
  logic [NUM_ENTRIES-1:0] unused_rsvd;

  logic [1:0]         eff_priv;
  logic [PADDR_W-1:0] last_b;
  logic               allow_c;

  pmp_regs #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .XLEN       (XLEN),
    .AREG_W     (AREG_W),
    .IDX_W      (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_is_cfg(csr_is_cfg),
    .csr_idx   (csr_idx),
    .csr_wdata (csr_wdata),
    .cfg_q     (cfg_q),
    .addr_q    (addr_q)
  );

  assign eff_priv = (chk_priv == PRIV_M && chk_mprv && chk_type != ACC_FETCH)
                    ? chk_mpp : chk_priv;
  assign last_b   = chk_addr + PADDR_W'((32'd1 << chk_size) - 32'd1);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    logic [AREG_W-1:0] prev_a;
    if (e == 0) begin : g_first
      assign prev_a = '0;
    end else begin : g_rest
      assign prev_a = addr_q[e-1];
    end

    pmp_region #(
      .PADDR_W(PADDR_W),
      .AREG_W (AREG_W)
    ) u_region (
      .mode     (cfg_q[e].mode),
      .addr_this(addr_q[e]),
      .addr_prev(prev_a),
      .first_b  (chk_addr),
      .last_b   (last_b),
      .hit_full (hit_full[e]),
      .hit_part (hit_part[e])
    );

    assign perm_r[e]      = cfg_q[e].r;
    assign perm_w[e]      = cfg_q[e].w;
    assign perm_x[e]      = cfg_q[e].x;
    assign locked[e]      = cfg_q[e].lock;
    assign unused_rsvd[e] = ^cfg_q[e].rsvd;
  end

  pmp_decide #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_decide (
    .hit_full(hit_full),
    .hit_part(hit_part),
    .perm_r  (perm_r),
    .perm_w  (perm_w),
    .perm_x  (perm_x),
    .locked  (locked),
    .acc     (chk_type),
    .priv    (eff_priv),
    .allow   (allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_allow <= chk_valid && allow_c;
    end
  end

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int AREG_W      = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_valid,
  input logic [1:0]        chk_type,
  input logic [1:0]        chk_priv,
  input logic              chk_mprv,
  input logic [1:0]        chk_mpp,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input ecfg_t             cfg_q  [NUM_ENTRIES],
  input logic [AREG_W-1:0] addr_q [NUM_ENTRIES]
);

  logic none_on;
  logic low_priv;

  always_comb begin
    none_on = 1'b1;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (cfg_q[i].mode != AM_OFF) none_on = 1'b0;
  end

  assign low_priv = (chk_priv != PRIV_M) ||
                    (chk_mprv && chk_type != ACC_FETCH && chk_mpp != PRIV_M);

  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid && !rsp_allow);

  // R13
  allow_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> rsp_valid);

  // R5
  none_on_denies_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid && none_on && low_priv |=> !rsp_allow);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_lock
    // R3
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_q[e].lock |=> $stable(cfg_q[e]) && $stable(addr_q[e]));
  end

endmodule

bind pmp_checker pmp_checker_sva #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .AREG_W     (AREG_W)
) u_sva (
  .clk      (clk),
  .rst      (rst),
  .chk_valid(chk_valid),
  .chk_type (chk_type),
  .chk_priv (chk_priv),
  .chk_mprv (chk_mprv),
  .chk_mpp  (chk_mpp),
  .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow),
  .cfg_q    (cfg_q),
  .addr_q   (addr_q)
);

// File: tb/sim_pmp_checker.sv
module sim_pmp_checker;

  localparam int NE = 16;
  localparam int XL = 64;
  localparam int PW = 34;

  typedef struct packed {
    logic [PW-1:0] a;
    logic [1:0]    sz;
    logic [1:0]    ty;
    logic [1:0]    pv;
    logic          mprv;
    logic [1:0]    mpp;
    logic          exp;
    logic [4:0]    rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{34'h000001000, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 5'd10}, // R10 TOR start
    '{34'h000001FFC, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd10}, // R10 TOR end
    '{34'h000001800, 2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 5'd10}, // R10 no W
    '{34'h000001000, 2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 5'd4 }, // R4 off entry RWX ignored
    '{34'h087654FFF, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 5'd7 }, // R7 last byte
    '{34'h087654FF8, 2'd3, 2'd2, 2'd0, 1'b0, 2'd0, 1'b1, 5'd7 }, // R7 8B ending on last byte
    '{34'h087654FFE, 2'd2, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 5'd8 }, // R8 straddle top
    '{34'h000001FFE, 2'd2, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 5'd8 }, // R8 straddle in M
    '{34'h000005000, 2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 5'd9 }, // R9 NA4 word
    '{34'h000005004, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 5'd9 }, // R9 just past
    '{34'h000005002, 2'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd9 }, // R9 half inside
    '{34'h000005002, 2'd2, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd9 }, // R9 runs past end
    '{34'h000006004, 2'd2, 2'd2, 2'd1, 1'b0, 2'd0, 1'b1, 5'd11}, // R11 8B region
    '{34'h000006008, 2'd0, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 5'd11}, // R11 past 8B
    '{34'h000006000, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 5'd12}, // R12 lower entry wins
    '{34'h087654000, 2'd2, 2'd0, 2'd3, 1'b1, 2'd1, 1'b1, 5'd6 }, // R6 M as S load
    '{34'h087654000, 2'd2, 2'd1, 2'd3, 1'b1, 2'd1, 1'b0, 5'd6 }, // R6 M as S store
    '{34'h087654000, 2'd2, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1, 5'd14}, // R14 M unlocked
    '{34'h000005000, 2'd2, 2'd2, 2'd3, 1'b1, 2'd1, 1'b1, 5'd6 }, // R6 fetch keeps M
    '{34'h00000A000, 2'd0, 2'd0, 2'd3, 1'b0, 2'd0, 1'b1, 5'd14}, // R14 M no match
    '{34'h00000A000, 2'd0, 2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 5'd6 }, // R6 M as U no match
    '{34'h000009000, 2'd2, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 5'd3 }, // R3 locked M store
    '{34'h000009000, 2'd2, 2'd0, 2'd3, 1'b0, 2'd0, 1'b1, 5'd3 }, // R3 locked M load
    '{34'h00000A000, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd5 }  // R5 U no match
  };

  logic          clk;
  logic          rst;
  logic          csr_we;
  logic          csr_is_cfg;
  logic [3:0]    csr_idx;
  logic [XL-1:0] csr_wdata;
  logic          chk_valid;
  logic [PW-1:0] chk_addr;
  logic [1:0]    chk_size;
  logic [1:0]    chk_type;
  logic [1:0]    chk_priv;
  logic          chk_mprv;
  logic [1:0]    chk_mpp;
  logic          rsp_valid;
  logic          rsp_allow;

  int checks = 0;
  int errors = 0;

  pmp_checker #(.NUM_ENTRIES(NE), .XLEN(XL), .PADDR_W(PW)) u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_is_cfg(csr_is_cfg),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .chk_size(chk_size), .chk_type(chk_type),
    .chk_priv(chk_priv), .chk_mprv(chk_mprv), .chk_mpp(chk_mpp),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic csr_wr(input logic is_cfg, input logic [3:0] idx, input logic [XL-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_is_cfg = is_cfg; csr_idx = idx; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic probe(input logic [PW-1:0] a, input logic [1:0] sz, input logic [1:0] ty,
                       input logic [1:0] pv, input logic mprv, input logic [1:0] mpp,
                       input logic exp, input string tag);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_size = sz; chk_type = ty;
    chk_priv = pv; chk_mprv = mprv; chk_mpp = mpp;
    @(negedge clk);
    chk_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual valid=%b allow=%b expected valid=1 allow=%b",
               tag, a, rsp_valid, rsp_allow, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; csr_we = 1'b0; csr_is_cfg = 1'b0; csr_idx = '0; csr_wdata = '0;
    chk_valid = 1'b0; chk_addr = '0; chk_size = '0; chk_type = '0;
    chk_priv = '0; chk_mprv = 1'b0; chk_mpp = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset actual valid=%b allow=%b expected 0 0", rsp_valid, rsp_allow);
    end
    rst = 1'b0;
    @(negedge clk);

    // R5 every entry off after reset
    probe(34'h0, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R5 S load none on");
    probe(34'h100, 2'd2, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, "R5 U fetch none on");
    probe(34'h0, 2'd0, 2'd0, 2'd3, 1'b0, 2'd0, 1'b1, "R5 M load none on");

    // R2 address words, then R1 configuration word 0
    csr_wr(1'b0, 4'd0, 64'h400);
    csr_wr(1'b0, 4'd1, 64'h800);
    csr_wr(1'b0, 4'd2, 64'h1400);
    csr_wr(1'b0, 4'd3, 64'h21D951FF);
    csr_wr(1'b0, 4'd4, 64'h1800);
    csr_wr(1'b0, 4'd5, 64'h1800);
    csr_wr(1'b0, 4'd7, 64'h2400);
    csr_wr(1'b0, 4'd8, 64'h29FF);
    csr_wr(1'b1, 4'd0, 64'h9100_131C_1D13_0907);

    for (int i = 0; i < NV; i++)
      probe(TBL[i].a, TBL[i].sz, TBL[i].ty, TBL[i].pv, TBL[i].mprv, TBL[i].mpp,
            TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].rq, i));

    // R1 odd index reaches no entry
    csr_wr(1'b1, 4'd1, 64'h1F1F_1F1F_1F1F_1F1F);
    probe(34'h6000, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R1 odd index ignored");

    // R1 index 2 byte 0 lands in entry 8
    csr_wr(1'b1, 4'd2, 64'h19);
    probe(34'hA000, 2'd0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, "R1 entry 8 read");
    probe(34'hAFFF, 2'd0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, "R1 entry 8 no write");

    // R3 locked entry 7 ignores new address and config
    csr_wr(1'b0, 4'd7, 64'h2C00);
    csr_wr(1'b1, 4'd0, 64'h1700_131C_1D13_0907);
    probe(34'h9000, 2'd2, 2'd1, 2'd3, 1'b0, 2'd0, 1'b0, "R3 lock kept");
    probe(34'h9000, 2'd2, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, "R3 address kept");
    probe(34'hB000, 2'd2, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R3 new address ignored");

    // R2 moving an unlocked four-byte entry
    csr_wr(1'b0, 4'd2, 64'h1440);
    probe(34'h5100, 2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, "R2 moved entry");
    probe(34'h5000, 2'd2, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, "R2 old place");

    // R13 no request, no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0) begin
      errors++;
      $display("FAIL R13 idle actual valid=%b allow=%b expected 0 0", rsp_valid, rsp_allow);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule